// File: doc/BRIEF.md
# Gated UART Receiver

This block turns an asynchronous serial line into received words of 8 or 9 bits and places each word in a one-entry receive holding register. The line is sampled on a baud tick that runs at sixteen times the bit rate. A configuration input can take the line from the local transmit wire instead of the receive pin, and another can invert the line before it is sampled. Optional parity is checked, and a missing stop bit is reported as a framing error.

A gate flag lets software discard traffic that is not addressed to this node. While the gate is closed, ordinary words are dropped and the holding register does not change. Two kinds of word can still pass. The first is an address word, whose ninth bit matches a programmed value while address mode is on. The second is a programmed start word, which also opens the gate. A data-ready request follows the holding register. This request can be switched off automatically when an error occurs and stays off until software turns it back on.

Top module: `uart_rx_gate`

## Requirements
- R1: After reset, buf_valid, req_data, blocked, addr_seen, parity_err, frame_err and overflow are all 0.
- R2: A word is sent as a low start bit, then data bits with the least significant bit first, then an optional parity bit, then a high stop bit. Each bit lasts 16 baud ticks. In 8-bit mode (cfg_nine=0) the word appears in buf_data with bit 8 equal to 0, buf_valid goes to 1, and req_data goes to 1.
- R3: With cfg_nine=1, nine data bits are received and buf_data[8] holds the ninth.
- R4: With cfg_par_en=1 a parity bit follows the data. It is even parity (the XOR of the data bits) when cfg_par_odd=0 and its complement when cfg_par_odd=1. A mismatch sets the sticky parity_err flag, and the word is still stored.
- R5: Only one stop bit is checked. If it is low, the sticky frame_err flag is set. A new start bit right after a single stop bit is received as a new word.
- R6: A start bit is accepted only if the line is still low at the eighth tick of the start bit. A shorter low pulse produces no word.
- R7: cmd_block_set sets blocked and cmd_block_clr clears it; clear wins when both are high. While blocked=1, ordinary words are dropped and buf_valid and buf_data are left unchanged.
- R8: With cfg_mp_en=1 and cfg_nine=1, a word whose bit 8 equals cfg_mp_addr is stored even while blocked=1, and it sets the sticky addr_seen flag. With cfg_mp_en=0, bit 8 has no special effect.
- R9: With cfg_sf_en=1, a word equal to cfg_sf_word clears blocked and is stored. With cfg_sf_en=0, the same word leaves blocked unchanged.
- R10: With cfg_loop=1 the receiver samples tx_loop and ignores rx_pin.
- R11: With cfg_inv=1 the selected line is inverted before sampling, so the idle level on the wire is low.
- R12: req_data is buf_valid gated by an enable bit. If cfg_err_gate=1, a parity or framing error clears the enable, and only a cmd_req_on pulse sets it again.
- R13: A word that is accepted while buf_valid=1 and buf_pop=0 is dropped, leaves buf_data unchanged, and sets the sticky overflow flag. flags_clr clears all the sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Sampling strobe at 16x the bit rate |
| rx_pin | input | 1 | Serial receive pin |
| tx_loop | input | 1 | Local transmit wire, used when loopback is on |
| cfg_inv | input | 1 | Invert the line before sampling |
| cfg_loop | input | 1 | Take the line from tx_loop |
| cfg_nine | input | 1 | Nine data bits per word |
| cfg_par_en | input | 1 | A parity bit is present |
| cfg_par_odd | input | 1 | Odd parity when set |
| cfg_mp_en | input | 1 | Address-word mode |
| cfg_mp_addr | input | 1 | Value of bit 8 that marks an address word |
| cfg_sf_en | input | 1 | A matching start word opens the gate |
| cfg_sf_word | input | 9 | Start word value |
| cfg_err_gate | input | 1 | Errors switch off the data request |
| cmd_block_set | input | 1 | Close the gate |
| cmd_block_clr | input | 1 | Open the gate |
| cmd_req_on | input | 1 | Re-enable the data request |
| flags_clr | input | 1 | Clear the sticky flags |
| buf_pop | input | 1 | Consume the held word |
| buf_data | output | 9 | Held word |
| buf_valid | output | 1 | Holding register is full |
| req_data | output | 1 | Data-ready request |
| blocked | output | 1 | Gate flag |
| addr_seen | output | 1 | Sticky: address word received |
| parity_err | output | 1 | Sticky: parity mismatch |
| frame_err | output | 1 | Sticky: stop bit low |
| overflow | output | 1 | Sticky: word lost because the register was full |

## Verification
The line passes through a two-stage synchronizer, and the start is then confirmed eight ticks later. With a tick on every clock, each bit is therefore sampled about ten clocks after it is driven. Every result of a word (buf_data, buf_valid, the error and address flags, overflow, blocked, and the request enable) is registered one clock after the tick that samples the stop bit. That tick falls roughly two thirds of the way into the stop bit. The bench drives each bit for exactly 16 clocks and reads the outputs on a falling edge after the stop bit and a short idle gap, so the results have always settled by then. Command pulses last one cycle and are checked at the next falling edge.

// File: rtl/uart_rx_gate.sv
module uart_rx_gate #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx_pin,
  input  logic          tx_loop,
  input  logic          cfg_inv,
  input  logic          cfg_loop,
  input  logic          cfg_nine,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_mp_en,
  input  logic          cfg_mp_addr,
  input  logic          cfg_sf_en,
  input  logic [DW-1:0] cfg_sf_word,
  input  logic          cfg_err_gate,
  input  logic          cmd_block_set,
  input  logic          cmd_block_clr,
  input  logic          cmd_req_on,
  input  logic          flags_clr,
  input  logic          buf_pop,
  output logic [DW-1:0] buf_data,
  output logic          buf_valid,
  output logic          req_data,
  output logic          blocked,
  output logic          addr_seen,
  output logic          parity_err,
  output logic          frame_err,
  output logic          overflow
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

  rx_state_t      st;
  logic [1:0]     sync;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bit_n;
  logic [DW-1:0]  shreg;
  logic           pbit, armed, req_en;

  wire line   = (cfg_loop ? tx_loop : rx_pin) ^ cfg_inv;
  wire rxs    = sync[1];
  wire at_end = baud_tick && cnt == LAST;
  wire fin    = at_end && st == S_STOP;
  wire [BW-1:0] last_bit = cfg_nine ? BW'(DW - 1) : BW'(DW - 2);

  wire [DW-1:0] word = cfg_nine ? shreg : {1'b0, shreg[DW-1:1]};
  wire par_exp  = cfg_par_odd ? ~^word : ^word;
  wire perr_now = cfg_par_en && (pbit != par_exp);
  wire ferr_now = !rxs;
  wire err_now  = perr_now || ferr_now;
  wire addr_hit = cfg_mp_en && cfg_nine && (word[DW-1] == cfg_mp_addr);
  wire sf_hit   = cfg_sf_en && (word == cfg_sf_word);
  wire accept   = fin && (!blocked || addr_hit || sf_hit);
  wire room     = !buf_valid || buf_pop;

  assign req_data = buf_valid && req_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bit_n <= '0; shreg <= '0; pbit <= 1'b0; armed <= 1'b0;
    end else if (baud_tick) begin
      case (st)
        S_IDLE:
          if (rxs) armed <= 1'b1;
          else if (armed) begin st <= S_START; cnt <= '0; end
        S_START:
          if (cnt == MID) begin
            cnt <= '0; bit_n <= '0;
            st  <= rxs ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (at_end) begin
            cnt   <= '0;
            shreg <= {rxs, shreg[DW-1:1]};
            bit_n <= bit_n + 1'b1;
            if (bit_n == last_bit) st <= cfg_par_en ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (at_end) begin cnt <= '0; pbit <= rxs; st <= S_STOP; end
          else cnt <= cnt + 1'b1;
        S_STOP:
          if (at_end) begin cnt <= '0; armed <= 1'b0; st <= S_IDLE; end
          else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data <= '0; buf_valid <= 1'b0;
    end else if (accept && room) begin
      buf_data <= word; buf_valid <= 1'b1;
    end else if (buf_pop) begin
      buf_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 blocked <= 1'b0;
    else if (cmd_block_clr)     blocked <= 1'b0;
    else if (cmd_block_set)     blocked <= 1'b1;
    else if (fin && sf_hit)     blocked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           req_en <= 1'b1;
    else if (fin && err_now && cfg_err_gate) req_en <= 1'b0;
    else if (cmd_req_on)                  req_en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_seen <= 1'b0; parity_err <= 1'b0; frame_err <= 1'b0; overflow <= 1'b0;
    end else if (flags_clr) begin
      addr_seen <= 1'b0; parity_err <= 1'b0; frame_err <= 1'b0; overflow <= 1'b0;
    end else begin
      if (fin && addr_hit)  addr_seen  <= 1'b1;
      if (fin && perr_now)  parity_err <= 1'b1;
      if (fin && ferr_now)  frame_err  <= 1'b1;
      if (accept && !room)  overflow   <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_gate_chk.sv
module uart_rx_gate_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_nine,
  input logic          cfg_mp_en,
  input logic          cfg_sf_en,
  input logic          cmd_block_clr,
  input logic          buf_pop,
  input logic [DW-1:0] buf_data,
  input logic          buf_valid,
  input logic          req_data,
  input logic          blocked,
  input logic          addr_seen,
  input logic          overflow
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!buf_valid && !blocked && !overflow && !addr_seen));

  a_r12_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    req_data |-> buf_valid);

  a_r13_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_pop) |=> $stable(buf_data));

  a_r13_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(buf_valid));

  a_r8_addr_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_seen) |-> ($past(cfg_mp_en) && $past(cfg_nine)));

  a_r9_unblock_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blocked) |-> ($past(cmd_block_clr) || $past(cfg_sf_en)));

  a_r7_gate_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !buf_valid && !cfg_mp_en && !cfg_sf_en) |=> !buf_valid);
endmodule

bind uart_rx_gate uart_rx_gate_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_uart_rx_gate.sv
`timescale 1ns/1ps
module test_uart_rx_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_inv = 0, cfg_loop = 0, cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic cfg_mp_en = 0, cfg_mp_addr = 0, cfg_sf_en = 0, cfg_err_gate = 0;
  logic [8:0] cfg_sf_word = 9'h000;
  logic cmd_block_set = 0, cmd_block_clr = 0, cmd_req_on = 0, flags_clr = 0, buf_pop = 0;
  logic lvl = 1'b1;
  logic rx_pin, tx_loop;
  logic [8:0] buf_data;
  logic buf_valid, req_data, blocked, addr_seen, parity_err, frame_err, overflow;

  assign rx_pin  = (cfg_loop ? 1'b0 : lvl) ^ cfg_inv;
  assign tx_loop = (cfg_loop ? lvl : 1'b1) ^ cfg_inv;

  uart_rx_gate i_uart_rx_gate (
    .clk, .rst_n, .baud_tick(1'b1), .rx_pin, .tx_loop,
    .cfg_inv, .cfg_loop, .cfg_nine, .cfg_par_en, .cfg_par_odd,
    .cfg_mp_en, .cfg_mp_addr, .cfg_sf_en, .cfg_sf_word, .cfg_err_gate,
    .cmd_block_set, .cmd_block_clr, .cmd_req_on, .flags_clr, .buf_pop,
    .buf_data, .buf_valid, .req_data, .blocked, .addr_seen,
    .parity_err, .frame_err, .overflow);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic bp, input logic bs, input int gap);
    logic [8:0] w;
    w = cfg_nine ? d : {1'b0, d[7:0]};
    lvl = 1'b0; wait_n(16);
    for (int i = 0; i < (cfg_nine ? 9 : 8); i++) begin lvl = w[i]; wait_n(16); end
    if (cfg_par_en) begin lvl = (cfg_par_odd ? ~^w : ^w) ^ bp; wait_n(16); end
    lvl = ~bs; wait_n(16);
    lvl = 1'b1; wait_n(gap);
  endtask

  task automatic pulse_clean();
    buf_pop = 1; flags_clr = 1; wait_n(1);
    buf_pop = 0; flags_clr = 0; wait_n(1);
  endtask

  // {nine, par_en, par_odd, inv, loop, bad_par, bad_stop, data[8:0], exp_perr, exp_ferr}
  localparam logic [17:0] VEC [11] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,9'h0A5,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,9'h03C,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,9'h081,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,9'h007,1'b1,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,9'h0F0,1'b0,1'b1},
    {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,9'h155,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,9'h0FE,1'b0,1'b0},
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,9'h05A,1'b0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,9'h0C3,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,9'h096,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,9'h1FF,1'b0,1'b1}
  };

  initial begin
    wait_n(4); rst_n = 1; wait_n(2);
    // R1 reset state
    chk("R1 reset outputs",
        {25'd0, buf_valid, req_data, blocked, addr_seen, parity_err, frame_err, overflow}, 32'd0);

    // R2 R3 R4 R5 R10 R11 vector walk
    for (int k = 0; k < 11; k++) begin
      logic [17:0] v;
      logic [8:0] ed;
      v = VEC[k];
      pulse_clean();
      {cfg_nine, cfg_par_en, cfg_par_odd, cfg_inv, cfg_loop} = v[17:13];
      wait_n(4);
      send(v[10:2], v[12], v[11], 20);
      ed = v[17] ? v[10:2] : {1'b0, v[9:2]};
      chk($sformatf("R2 R3 R10 R11 vector %0d data", k),
          {22'd0, buf_valid, req_data, ed === buf_data}, {22'd0, 1'b1, 1'b1, 1'b1});
      chk($sformatf("R4 R5 vector %0d flags", k),
          {30'd0, parity_err, frame_err}, {30'd0, v[1], v[0]});
    end
    pulse_clean();
    {cfg_nine, cfg_par_en, cfg_par_odd, cfg_inv, cfg_loop} = '0;
    wait_n(4);

    // R6 short low pulse
    lvl = 0; wait_n(5); lvl = 1; wait_n(60);
    chk("R6 glitch ignored", {31'd0, buf_valid}, 32'd0);

    // R7 gate closes and drops
    cmd_block_set = 1; wait_n(1); cmd_block_set = 0; wait_n(1);
    chk("R7 blocked set", {31'd0, blocked}, 32'd1);
    send(9'h055, 0, 0, 20);
    chk("R7 dropped while blocked", {31'd0, buf_valid}, 32'd0);

    // R8 address word
    cfg_nine = 1; cfg_mp_addr = 1; wait_n(2);
    send(9'h1AA, 0, 0, 20);
    chk("R8 mode off ninth bit plain", {30'd0, buf_valid, addr_seen}, 32'd0);
    cfg_mp_en = 1; wait_n(2);
    send(9'h1AA, 0, 0, 20);
    chk("R8 address passes gate", {20'd0, buf_data, buf_valid, addr_seen, blocked},
        {20'd0, 9'h1AA, 1'b1, 1'b1, 1'b1});
    pulse_clean();
    cfg_mp_en = 0; cfg_nine = 0; wait_n(2);

    // R9 start word
    cfg_sf_word = 9'h03C; wait_n(2);
    send(9'h03C, 0, 0, 20);
    chk("R9 start word ignored when disabled", {30'd0, buf_valid, blocked}, 32'd1);
    cfg_sf_en = 1; wait_n(2);
    send(9'h03C, 0, 0, 20);
    chk("R9 start word unblocks", {21'd0, buf_data, buf_valid, blocked},
        {21'd0, 9'h03C, 1'b1, 1'b0});
    pulse_clean();
    cfg_sf_en = 0;

    // R7 clear wins over set
    cmd_block_set = 1; cmd_block_clr = 1; wait_n(1);
    cmd_block_set = 0; cmd_block_clr = 0; wait_n(1);
    chk("R7 clear priority", {31'd0, blocked}, 32'd0);

    // R12 error gates request
    cfg_err_gate = 1; cfg_par_en = 1; wait_n(2);
    send(9'h011, 1, 0, 20);
    chk("R12 request off after error", {30'd0, buf_valid, req_data}, 32'd2);
    pulse_clean();
    send(9'h022, 0, 0, 20);
    chk("R12 request stays off", {30'd0, buf_valid, req_data}, 32'd2);
    cmd_req_on = 1; wait_n(1); cmd_req_on = 0; wait_n(1);
    chk("R12 request re-enabled", {31'd0, req_data}, 32'd1);
    pulse_clean();
    cfg_err_gate = 0; cfg_par_en = 0; wait_n(2);

    // R5 R13 back-to-back words, second overflows
    send(9'h0A1, 0, 0, 0);
    send(9'h0B2, 0, 0, 20);
    chk("R5 R13 second word seen after one stop", {31'd0, overflow}, 32'd1);
    chk("R13 held word kept", {23'd0, buf_data}, {23'd0, 9'h0A1});
    pulse_clean();
    chk("R13 flags cleared", {31'd0, overflow}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule